// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a 32-bit in-order core built as a five-stage pipeline: fetch, decode with register read, execute, memory and writeback. It executes a small load/store instruction subset: word load, word store, four register-to-register ALU operations and branch-if-equal. Instruction storage and data storage are separate arrays inside the block. The surrounding environment fills them through a load port while the core is held in reset. A debug read port returns any register-file entry, so results can be inspected from outside.

Every control decision for an instruction is made once, in decode. It then rides down the stage registers with the instruction, together with the destination register number that writeback uses. Operand forwarding is deliberately absent. The register file passes a value through when it is read in the same cycle it is written. Decode holds a dependent instruction until its producer has reached writeback. Branches are resolved late: the redirect is taken from the memory stage and discards the three younger instructions behind it.

Top module: `pipe_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0, marks every stage register empty and clears all 32 registers to zero. Instruction and data storage keep their contents.
- R2: With no dependencies, one instruction completes per clock. A load at address 0 becomes visible on the debug port after the 5th rising edge following reset release. An independent load at address 4 becomes visible one edge later.
- R3: Register-type instructions use opcode 0x00 with fields rs[25:21], rt[20:16], rd[15:11], shamt[10:6] = 0 and funct[5:0]. The supported funct codes are 0x20 add, 0x22 subtract (rs minus rt), 0x24 bitwise and, and 0x25 bitwise or. The result is written to rd.
- R4: Load (opcode 0x23) and store (opcode 0x2B) form the address as rs plus the sign-extended imm[15:0]. The data word index is address bits [DMEM_AW+1:2]. A load writes rt. A store writes rt's value to data storage, and a later load of the same address returns it.
- R5: Decode stalls an instruction whose source register (not r0) is the destination of a valid writing instruction in execute or memory. The stalled instruction issues once the producer is in writeback, and it receives the value being written in that cycle. The sequence r16=0x10010000, r12=0x24, mem[0x10010004]=0x60, load r9 from 4(r16), then r13 = r9 + r12, yields r9=0x60 and r13=0x84.
- R6: Branch-if-equal (opcode 0x04, rs, rt, imm) is taken when rs equals rt. Its target is PC+4 plus the sign-extended imm shifted left by 2. The redirect happens from the memory stage. The three instructions fetched after the branch never write a register, and the branch itself writes no register.
- R7: A branch whose operands differ lets the following instructions execute in order.
- R8: Register r0 reads as zero and ignores writes.
- R9: Any other opcode, any other funct code, and a register-type word with nonzero shamt act as no-ops that change no register.
- R10: When a taken branch and a decode stall occur in the same cycle, the redirect wins and the core continues from the branch target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ldEn | input | 1 | Write one preload word this cycle |
| ldToData | input | 1 | Preload target: 1 data storage, 0 instruction storage |
| ldAddr | input | LD_AW | Preload word index |
| ldData | input | 32 | Preload word |
| dbgAddr | input | 5 | Register number to inspect |
| dbgData | output | 32 | Contents of the selected register |

## Verification
The bench aims at the cycle where a redirect and a stall collide. If a design let the stall win, it would hold the PC and lose the branch, so the target instruction would never write its register. A load followed by a dependent add checks the interlock and the pass-through read. A missing stall would leave the sum using the stale zero, and a missing pass-through would cost an extra cycle or produce a wrong value. A negative store offset checks sign extension, and the first-result edge count pins the pipeline depth and throughput. Writes to r0, unsupported encodings and squashed slots are each checked at the debug port to confirm they change nothing.

// File: rtl/pipe_pkg.sv
package pipe_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] FN_SUB   = 6'h22;
  localparam logic [5:0] FN_AND   = 6'h24;
  localparam logic [5:0] FN_OR    = 6'h25;

  typedef enum logic [1:0] {AluAdd, AluSub, AluAnd, AluOr} aluOp_e;

  // decoded control carried with an instruction from decode onward
  typedef struct packed {
    logic       regWrite;
    logic       memRead;
    logic       memWrite;
    logic       branch;
    logic       useImm;
    aluOp_e     aluOp;
    logic [4:0] dest;
  } decCtl_t;

  // strobes from control to datapath
  typedef struct packed {
    logic stall;
    logic flush;
  } pipeCtl_t;

  // datapath state that control needs to see
  typedef struct packed {
    logic        idValid;
    logic [31:0] idInstr;
    logic        exValid;
    logic        exRegWrite;
    logic [4:0]  exDest;
    logic        memValid;
    logic        memRegWrite;
    logic [4:0]  memDest;
    logic        memTaken;
  } pipeStat_t;
endpackage

// File: rtl/pipe_ctrl.sv
module pipe_ctrl
  import pipe_pkg::*;
(
  input  pipeStat_t stat,
  output decCtl_t   dec,
  output pipeCtl_t  pctl
);
  logic [5:0] op, fn;
  logic [4:0] rs, rt, rd, shamt;
  logic useRs, useRt;

  function automatic logic pending(input logic [4:0] r, input pipeStat_t s);
    return (r != 5'd0) &&
           ((s.exValid && s.exRegWrite && (s.exDest == r)) ||
            (s.memValid && s.memRegWrite && (s.memDest == r)));
  endfunction

  always_comb begin
    op    = stat.idInstr[31:26];
    rs    = stat.idInstr[25:21];
    rt    = stat.idInstr[20:16];
    rd    = stat.idInstr[15:11];
    shamt = stat.idInstr[10:6];
    fn    = stat.idInstr[5:0];
    dec   = '0;
    useRs = 1'b0;
    useRt = 1'b0;
    case (op)
      OP_RTYPE: begin
        if (shamt == 5'd0 &&
            (fn == FN_ADD || fn == FN_SUB || fn == FN_AND || fn == FN_OR)) begin
          dec.regWrite = 1'b1;
          dec.dest     = rd;
          useRs        = 1'b1;
          useRt        = 1'b1;
          case (fn)
            FN_SUB:  dec.aluOp = AluSub;
            FN_AND:  dec.aluOp = AluAnd;
            FN_OR:   dec.aluOp = AluOr;
            default: dec.aluOp = AluAdd;
          endcase
        end
      end
      OP_LOAD: begin
        dec.regWrite = 1'b1;
        dec.memRead  = 1'b1;
        dec.useImm   = 1'b1;
        dec.dest     = rt;
        useRs        = 1'b1;
      end
      OP_STORE: begin
        dec.memWrite = 1'b1;
        dec.useImm   = 1'b1;
        useRs        = 1'b1;
        useRt        = 1'b1;
      end
      OP_BEQ: begin
        dec.branch = 1'b1;
        dec.aluOp  = AluSub;
        useRs      = 1'b1;
        useRt      = 1'b1;
      end
      default: ;
    endcase
    pctl.flush = stat.memTaken;
    pctl.stall = stat.idValid &&
                 ((useRs && pending(rs, stat)) || (useRt && pending(rt, stat)));
  end
endmodule

// File: rtl/pipe_datapath.sv
module pipe_datapath
  import pipe_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int LD_AW   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ldEn,
  input  logic              ldToData,
  input  logic [LD_AW-1:0]  ldAddr,
  input  logic [31:0]       ldData,
  input  decCtl_t           dec,
  input  pipeCtl_t          pctl,
  output pipeStat_t         stat,
  input  logic [4:0]        dbgAddr,
  output logic [31:0]       dbgData
);
  localparam int IMEM_WORDS = 1 << IMEM_AW;
  localparam int DMEM_WORDS = 1 << DMEM_AW;
  localparam int NREGS      = 32;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf   [NREGS];

  // fetch / decode
  logic [31:0] pc, idInstr, idPc4;
  logic        idValid;
  // execute
  logic        exValid;
  decCtl_t     exCtl;
  logic [31:0] exA, exB, exImm, exPc4;
  // memory
  logic        memValid, memRegWrite, memRead, memWrite, memBranch, memZero;
  logic [4:0]  memDest;
  logic [31:0] memRes, memStore, memTarget;
  // writeback
  logic        wbValid, wbRegWrite;
  logic [4:0]  wbDest;
  logic [31:0] wbData;

  logic [4:0]  idRs, idRt;
  logic [31:0] rsVal, rtVal, idImm, opB, aluRes, exTarget, loadWord;
  logic        wbWe, memTaken;

  assign idRs  = idInstr[25:21];
  assign idRt  = idInstr[20:16];
  assign idImm = {{16{idInstr[15]}}, idInstr[15:0]};
  assign wbWe  = wbValid && wbRegWrite && (wbDest != 5'd0);

  // register read with pass-through of the value being written
  always_comb begin
    if (idRs == 5'd0)                     rsVal = '0;
    else if (wbWe && (wbDest == idRs))    rsVal = wbData;
    else                                  rsVal = rf[idRs];
    if (idRt == 5'd0)                     rtVal = '0;
    else if (wbWe && (wbDest == idRt))    rtVal = wbData;
    else                                  rtVal = rf[idRt];
  end

  always_comb begin
    opB = exCtl.useImm ? exImm : exB;
    case (exCtl.aluOp)
      AluSub:  aluRes = exA - opB;
      AluAnd:  aluRes = exA & opB;
      AluOr:   aluRes = exA | opB;
      default: aluRes = exA + opB;
    endcase
    exTarget = exPc4 + {exImm[29:0], 2'b00};
  end

  assign memTaken = memValid && memBranch && memZero;
  assign loadWord = dmem[memRes[DMEM_AW+1:2]];
  assign dbgData  = rf[dbgAddr];

  always_comb begin
    stat.idValid     = idValid;
    stat.idInstr     = idInstr;
    stat.exValid     = exValid;
    stat.exRegWrite  = exCtl.regWrite;
    stat.exDest      = exCtl.dest;
    stat.memValid    = memValid;
    stat.memRegWrite = memRegWrite;
    stat.memDest     = memDest;
    stat.memTaken    = memTaken;
  end

  // pipeline stage registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      idValid  <= 1'b0;
      exValid  <= 1'b0;
      memValid <= 1'b0;
      wbValid  <= 1'b0;
    end else begin
      if (pctl.flush) begin
        pc      <= memTarget;
        idValid <= 1'b0;
      end else if (!pctl.stall) begin
        pc      <= pc + 32'd4;
        idValid <= 1'b1;
        idInstr <= imem[pc[IMEM_AW+1:2]];
        idPc4   <= pc + 32'd4;
      end
      exValid <= idValid && !pctl.stall && !pctl.flush;
      exCtl   <= dec;
      exA     <= rsVal;
      exB     <= rtVal;
      exImm   <= idImm;
      exPc4   <= idPc4;

      memValid    <= exValid && !pctl.flush;
      memRegWrite <= exCtl.regWrite;
      memRead     <= exCtl.memRead;
      memWrite    <= exCtl.memWrite;
      memBranch   <= exCtl.branch;
      memDest     <= exCtl.dest;
      memRes      <= aluRes;
      memZero     <= (aluRes == 32'd0);
      memStore    <= exB;
      memTarget   <= exTarget;

      wbValid    <= memValid;
      wbRegWrite <= memRegWrite;
      wbDest     <= memDest;
      wbData     <= memRead ? loadWord : memRes;
    end
  end

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else if (wbWe) begin
      rf[wbDest] <= wbData;
    end
  end

  // instruction and data storage
  always_ff @(posedge clk) begin
    if (ldEn && !ldToData) imem[ldAddr[IMEM_AW-1:0]] <= ldData;
    if (ldEn && ldToData)
      dmem[ldAddr[DMEM_AW-1:0]] <= ldData;
    else if (!rst && memValid && memWrite)
      dmem[memRes[DMEM_AW+1:2]] <= memStore;
  end
endmodule

// File: rtl/pipe_core.sv
module pipe_core
  import pipe_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  localparam int LD_AW  = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ldEn,
  input  logic             ldToData,
  input  logic [LD_AW-1:0] ldAddr,
  input  logic [31:0]      ldData,
  input  logic [4:0]       dbgAddr,
  output logic [31:0]      dbgData
);
  decCtl_t   dec;
  pipeCtl_t  pctl;
  pipeStat_t stat;

  pipe_ctrl u_ctrl (
    .stat (stat),
    .dec  (dec),
    .pctl (pctl)
  );

  pipe_datapath #(
    .IMEM_AW (IMEM_AW),
    .DMEM_AW (DMEM_AW),
    .LD_AW   (LD_AW)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ldEn     (ldEn),
    .ldToData (ldToData),
    .ldAddr   (ldAddr),
    .ldData   (ldData),
    .dec      (dec),
    .pctl     (pctl),
    .stat     (stat),
    .dbgAddr  (dbgAddr),
    .dbgData  (dbgData)
  );
endmodule

// File: rtl/pipe_core_chk.sv
module pipe_core_chk
  import pipe_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input pipeStat_t stat,
  input pipeCtl_t  pctl
);
  // R1: reset empties every stage
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!stat.idValid && !stat.exValid && !stat.memValid));

  // R6: a redirect only comes from a valid memory-stage instruction
  a_r6_flush_from_mem: assert property (@(posedge clk) disable iff (rst)
    pctl.flush |-> stat.memValid);

  // R6: the three younger slots are emptied by a redirect
  a_r6_flush_squash: assert property (@(posedge clk) disable iff (rst)
    pctl.flush |=> (!stat.idValid && !stat.exValid && !stat.memValid));

  // R5: a stall inserts a bubble into execute
  a_r5_stall_bubble: assert property (@(posedge clk) disable iff (rst)
    (pctl.stall && !pctl.flush) |=> !stat.exValid);

  // R5: a stall keeps the same instruction in decode
  a_r5_stall_holds_decode: assert property (@(posedge clk) disable iff (rst)
    (pctl.stall && !pctl.flush) |=> (stat.idValid && $stable(stat.idInstr)));

  // R5: a stall only happens while a writing producer is in flight
  a_r5_stall_has_producer: assert property (@(posedge clk) disable iff (rst)
    pctl.stall |-> ((stat.exValid && stat.exRegWrite) ||
                    (stat.memValid && stat.memRegWrite)));
endmodule

bind pipe_core pipe_core_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .stat (stat),
  .pctl (pctl)
);

// File: tb/tb_pipe_core.sv
`timescale 1ns/1ps
module tb_pipe_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ldEn = 1'b0;
  logic        ldToData = 1'b0;
  logic [5:0]  ldAddr = '0;
  logic [31:0] ldData = '0;
  logic [4:0]  dbgAddr = '0;
  logic [31:0] dbgData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pipe_core dut (
    .clk(clk), .rst(rst), .ldEn(ldEn), .ldToData(ldToData),
    .ldAddr(ldAddr), .ldData(ldData), .dbgAddr(dbgAddr), .dbgData(dbgData)
  );

  function automatic logic [31:0] rtype(input logic [5:0] fn, input int rs, input int rt, input int rd);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] itype(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic putWord(input bit toData, input int idx, input logic [31:0] w);
    @(negedge clk);
    ldEn = 1'b1; ldToData = toData; ldAddr = 6'(idx); ldData = w;
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  // hold reset and blank instruction storage
  task automatic beginProg();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 64; i++) putWord(1'b0, i, 32'h0);
  endtask

  task automatic release_run(input int n);
    @(negedge clk);
    rst = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic more(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkReg(input string tag, input int r, input logic [31:0] exp);
    dbgAddr = 5'(r);
    #0.5;
    checks++;
    if (dbgData !== exp) begin
      errors++;
      $display("FAIL %s: r%0d got %h expected %h", tag, r, dbgData, exp);
    end
  endtask

  task automatic testThroughput();
    beginProg();
    putWord(1, 0, 32'h11);
    putWord(1, 1, 32'h22);
    putWord(0, 0, itype(6'h23, 0, 1, 0));
    putWord(0, 1, itype(6'h23, 0, 2, 4));
    release_run(4);
    checkReg("R2 not before edge 5", 1, 32'h0);
    more(1);
    checkReg("R2 first result edge 5", 1, 32'h11);
    checkReg("R2 second not yet", 2, 32'h0);
    more(1);
    checkReg("R2 second result edge 6", 2, 32'h22);
  endtask

  task automatic testReset();
    beginProg();
    release_run(5);
    checkReg("R1 regfile cleared", 1, 32'h0);
    checkReg("R1 regfile cleared", 2, 32'h0);
    checkReg("R1 regfile cleared", 31, 32'h0);
  endtask

  task automatic testLoadUse();
    beginProg();
    putWord(1, 0, 32'h10010000);
    putWord(1, 1, 32'h60);
    putWord(1, 2, 32'h24);
    putWord(0, 0, itype(6'h23, 0, 16, 0));
    putWord(0, 1, itype(6'h23, 0, 12, 8));
    putWord(0, 2, itype(6'h23, 16, 9, 4));
    putWord(0, 3, rtype(6'h20, 9, 12, 13));
    release_run(40);
    checkReg("R5 base", 16, 32'h10010000);
    checkReg("R5 load-use load", 9, 32'h60);
    checkReg("R5 load-use sum", 13, 32'h84);
  endtask

  task automatic testAlu();
    logic [31:0] a = 32'h0F0F00F5;
    logic [31:0] b = 32'h00FF0F0A;
    beginProg();
    putWord(1, 3, a);
    putWord(1, 4, b);
    putWord(0, 0, itype(6'h23, 0, 1, 12));
    putWord(0, 1, itype(6'h23, 0, 2, 16));
    putWord(0, 2, rtype(6'h20, 1, 2, 3));
    putWord(0, 3, rtype(6'h22, 1, 2, 4));
    putWord(0, 4, rtype(6'h24, 1, 2, 5));
    putWord(0, 5, rtype(6'h25, 1, 2, 6));
    putWord(0, 6, rtype(6'h22, 2, 1, 7));
    release_run(40);
    checkReg("R3 add", 3, a + b);
    checkReg("R3 sub", 4, a - b);
    checkReg("R3 and", 5, a & b);
    checkReg("R3 or", 6, a | b);
    checkReg("R3 sub wraps", 7, b - a);
  endtask

  task automatic testMem();
    beginProg();
    putWord(1, 5, 32'hCAFEF00D);
    putWord(1, 6, 32'h100);
    putWord(1, 63, 32'h0);
    putWord(0, 0, itype(6'h23, 0, 1, 20));
    putWord(0, 1, itype(6'h23, 0, 2, 24));
    putWord(0, 2, itype(6'h2B, 2, 1, -4));
    putWord(0, 3, itype(6'h23, 0, 3, 32'hFC));
    release_run(40);
    checkReg("R4 store then load, negative offset", 3, 32'hCAFEF00D);
    checkReg("R4 store writes no register", 2, 32'h100);
  endtask

  task automatic testBranchTaken();
    beginProg();
    putWord(1, 7, 32'd5);
    putWord(1, 8, 32'd5);
    putWord(0, 0, itype(6'h23, 0, 1, 28));
    putWord(0, 1, itype(6'h23, 0, 2, 32));
    putWord(0, 2, itype(6'h04, 1, 2, 4));
    putWord(0, 3, rtype(6'h20, 1, 2, 3));
    putWord(0, 4, rtype(6'h20, 3, 1, 4));
    putWord(0, 5, rtype(6'h20, 1, 2, 5));
    putWord(0, 6, rtype(6'h20, 1, 2, 6));
    putWord(0, 7, rtype(6'h20, 1, 2, 7));
    release_run(50);
    checkReg("R6 squashed slot 1", 3, 32'h0);
    checkReg("R6 squashed slot 2", 4, 32'h0);
    checkReg("R6 squashed slot 3", 5, 32'h0);
    checkReg("R6 skipped word", 6, 32'h0);
    checkReg("R10 target reached despite stall", 7, 32'd10);
    checkReg("R6 branch writes no register", 2, 32'd5);
  endtask

  task automatic testBranchNot();
    beginProg();
    putWord(1, 7, 32'd5);
    putWord(1, 9, 32'd6);
    putWord(0, 0, itype(6'h23, 0, 1, 28));
    putWord(0, 1, itype(6'h23, 0, 2, 36));
    putWord(0, 2, itype(6'h04, 1, 2, 4));
    putWord(0, 3, rtype(6'h20, 1, 2, 3));
    putWord(0, 4, rtype(6'h20, 3, 1, 4));
    putWord(0, 5, rtype(6'h20, 1, 2, 5));
    release_run(50);
    checkReg("R7 fall through 1", 3, 32'd11);
    checkReg("R7 fall through 2", 4, 32'd16);
    checkReg("R7 fall through 3", 5, 32'd11);
  endtask

  task automatic testZeroReg();
    beginProg();
    putWord(1, 7, 32'd5);
    putWord(0, 0, itype(6'h23, 0, 0, 28));
    putWord(0, 1, itype(6'h23, 0, 1, 28));
    putWord(0, 2, rtype(6'h20, 0, 0, 8));
    putWord(0, 3, rtype(6'h20, 0, 1, 9));
    release_run(40);
    checkReg("R8 r0 stays zero", 0, 32'h0);
    checkReg("R8 r0 reads zero", 8, 32'h0);
    checkReg("R8 r0 plus r1", 9, 32'd5);
  endtask

  task automatic testUnsupported();
    beginProg();
    putWord(1, 7, 32'd5);
    putWord(0, 0, itype(6'h23, 0, 1, 28));
    putWord(0, 1, itype(6'h08, 1, 10, 5));
    putWord(0, 2, rtype(6'h21, 1, 1, 11));
    putWord(0, 3, rtype(6'h20, 1, 1, 14) | 32'h0000_0040);
    putWord(0, 4, rtype(6'h20, 1, 1, 12));
    release_run(40);
    checkReg("R9 unknown opcode", 10, 32'h0);
    checkReg("R9 unknown funct", 11, 32'h0);
    checkReg("R9 nonzero shamt", 14, 32'h0);
    checkReg("R9 pipeline continues", 12, 32'd10);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    testThroughput();
    testReset();
    testLoadUse();
    testAlu();
    testMem();
    testBranchTaken();
    testBranchNot();
    testZeroReg();
    testUnsupported();
    report();
  end
endmodule